// File: doc/BRIEF.md
# Stereo Digital Volume Path

This block sits between an audio source and a stereo DAC and shapes each sample pair on its way through. For every channel it applies an enable, an optional sign inversion and an 8-bit logarithmic volume with 0.375 dB resolution. An optional mono fold replaces both channels with their average ahead of the per-channel processing. Results are saturated to the sample width.

Control is written through a small register port. Volume codes land in pending registers. They reach the datapath only when a volume write also sets the update bit, and then both channels switch together. Settings are captured together with each sample, so one output sample is never computed from a mix of old and new settings. The path has a fixed two-cycle latency from input strobe to output strobe and accepts a sample on every cycle.

Top module: `dac_vol_path`

## Requirements
- R1: After reset, `out_valid` is 0, both outputs are 0, both channels are disabled, inversion and mono are off, and both active and pending volume codes are 0xC0.
- R2: Register map on `wr_addr`. Address 0 is control: bit 0 inverts left, bit 1 inverts right, bit 2 selects mono. Address 1 is left volume and address 2 is right volume, each with bit 15 as channel enable, bit 8 as update and bits 7:0 as the volume code. Address 3 has no effect. Enable, inversion and mono take effect as soon as they are written.
- R3: A volume write only loads that channel's pending code. A volume write with bit 8 set copies both pending codes, including the one being written, into the active codes in the same cycle. Active codes change at no other time.
- R4: Active code 0x00 makes that channel's output exactly 0.
- R5: For code c from 1 to 255, let k = c mod 16, e = floor(c/16) − 12 and M = round(2^14 · 10^(0.375·k/20)). The output is floor(s · M · 2^e / 2^14), where s is the pre-gain sample. Code 0xC0 therefore passes s unchanged, and each code step changes the gain by about 0.375 dB.
- R6: Any gain result outside the signed DATA_W range is clamped to the nearest bound.
- R7: When a channel's invert bit is set, its pre-gain sample is negated before the gain is applied. Negating the most negative value gives the most positive value.
- R8: With mono set, both channels take floor((left + right)/2) as their input. Each channel then applies its own inversion, gain and enable.
- R9: A disabled channel outputs 0, while `out_valid` still pulses.
- R10: `out_valid` rises exactly two clock edges after the edge that takes an `in_valid` sample, and a new sample may be presented on every cycle.
- R11: A sample uses the settings that were active before the edge that takes it. A register write on that same edge affects only later samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 16 | Register write data |
| in_valid | input | 1 | Input sample strobe |
| in_left | input | DATA_W | Left input sample, signed |
| in_right | input | DATA_W | Right input sample, signed |
| out_valid | output | 1 | Output sample strobe |
| out_left | output | DATA_W | Left output sample, signed |
| out_right | output | DATA_W | Right output sample, signed |

## Verification
The bench builds the block with DATA_W = 16 and MONO_EN = 1. The narrow sample width makes full-scale inputs and both clamp bounds cheap to exercise. The bench sweeps all 256 volume codes on both channels at once, over sample sets that include zero, ±1, mid-range values and both extremes, so every mantissa entry, every shift amount, the mute code and both saturation directions are checked against an arithmetic model. Directed sequences cover deferred updates, mono folding with inversion, per-channel disable, back-to-back samples, and a write that lands on the same edge as a sample.

// File: rtl/dvp_pkg.sv
package dvp_pkg;

   localparam int CODE_W     = 8;
   localparam int MANT_FRAC  = 14;
   localparam int MANT_W     = 15;
   localparam int EXP_W      = 5;
   localparam int WR_DATA_W  = 16;
   localparam int UNITY_EXP  = 12;
   localparam logic [CODE_W-1:0] UNITY_CODE = 8'hC0;

   localparam int BIT_INV_L = 0;
   localparam int BIT_INV_R = 1;
   localparam int BIT_MONO  = 2;
   localparam int BIT_UPD   = 8;
   localparam int BIT_EN    = 15;

   typedef enum logic [1:0] {
      SEL_CTRL  = 2'd0,
      SEL_VOL_L = 2'd1,
      SEL_VOL_R = 2'd2,
      SEL_NONE  = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic                     mute;
      logic signed [EXP_W-1:0]  expo;
      logic [MANT_W-1:0]        mant;
   } gain_t;

   typedef struct packed {
      logic              en;
      logic              inv;
      logic [CODE_W-1:0] code;
   } chan_cfg_t;

endpackage

// File: rtl/dvp_regs.sv
module dvp_regs
   import dvp_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [1:0]            wr_addr,
   input  logic [WR_DATA_W-1:0]  wr_data,
   output chan_cfg_t [1:0]       cfg,
   output logic                  mono
);

   logic [1:0][CODE_W-1:0] pend_q, pend_nx, act_q;
   logic [1:0]             en_q, inv_q;
   logic                   upd;
   logic                   unused_bits;

   assign unused_bits = ^wr_data[BIT_EN-1:BIT_UPD+1] ^ ^wr_data[7:3];

   always_comb begin
      pend_nx = pend_q;
      upd     = 1'b0;
      for (int ch = 0; ch < 2; ch++) begin
         if (wr_en && wr_addr == ((ch == 0) ? SEL_VOL_L : SEL_VOL_R)) begin
            pend_nx[ch] = wr_data[CODE_W-1:0];
            upd         = wr_data[BIT_UPD];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= {2{UNITY_CODE}};
         act_q  <= {2{UNITY_CODE}};
         en_q   <= '0;
         inv_q  <= '0;
         mono   <= 1'b0;
      end else begin
         pend_q <= pend_nx;
         if (upd) act_q <= pend_nx;
         if (wr_en && wr_addr == SEL_CTRL) begin
            inv_q <= {wr_data[BIT_INV_R], wr_data[BIT_INV_L]};
            mono  <= wr_data[BIT_MONO];
         end
         if (wr_en && wr_addr == SEL_VOL_L) en_q[0] <= wr_data[BIT_EN];
         if (wr_en && wr_addr == SEL_VOL_R) en_q[1] <= wr_data[BIT_EN];
      end
   end

   for (genvar ch = 0; ch < 2; ch++) begin : g_cfg
      assign cfg[ch].en   = en_q[ch];
      assign cfg[ch].inv  = inv_q[ch];
      assign cfg[ch].code = act_q[ch];
   end

   AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_data[BIT_UPD] && (wr_addr == SEL_VOL_L || wr_addr == SEL_VOL_R))
      |=> $stable(act_q)); // R3

   AST_UPDATE_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == SEL_VOL_L && wr_data[BIT_UPD])
      |=> (act_q[0] == $past(wr_data[CODE_W-1:0]))); // R3

   AST_UPDATE_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == SEL_VOL_R && wr_data[BIT_UPD])
      |=> (act_q[1] == $past(wr_data[CODE_W-1:0]))); // R3

endmodule

// File: rtl/dvp_gain_map.sv
module dvp_gain_map
   import dvp_pkg::*;
(
   input  logic [CODE_W-1:0] code,
   output gain_t             gain
);

   function automatic logic [MANT_W-1:0] mant_of(input logic [3:0] k);
      case (k)
         4'd0:  return 15'd16384;
         4'd1:  return 15'd17107;
         4'd2:  return 15'd17862;
         4'd3:  return 15'd18650;
         4'd4:  return 15'd19472;
         4'd5:  return 15'd20332;
         4'd6:  return 15'd21229;
         4'd7:  return 15'd22165;
         4'd8:  return 15'd23143;
         4'd9:  return 15'd24164;
         4'd10: return 15'd25230;
         4'd11: return 15'd26343;
         4'd12: return 15'd27506;
         4'd13: return 15'd28719;
         4'd14: return 15'd29986;
         default: return 15'd31309;
      endcase
   endfunction

   localparam logic signed [EXP_W-1:0] EXP_BIAS = EXP_W'(UNITY_EXP);

   always_comb begin
      gain.mute = (code == '0);
      gain.mant = mant_of(code[3:0]);
      gain.expo = $signed({1'b0, code[CODE_W-1:4]}) - EXP_BIAS;
   end

endmodule

// File: rtl/dvp_chan.sv
module dvp_chan
   import dvp_pkg::*;
#(
   parameter int DATA_W = 24
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     take,
   input  logic                     s1_valid,
   input  logic signed [DATA_W-1:0] x,
   input  logic                     inv,
   input  logic                     en,
   input  gain_t                    gain,
   output logic signed [DATA_W-1:0] y
);

   localparam int PW = DATA_W + MANT_W + 1;
   localparam int WW = PW + 4;
   localparam logic [5:0] FRAC_SH = 6'(MANT_FRAC);
   localparam logic signed [DATA_W-1:0] DMAX = {1'b0, {(DATA_W-1){1'b1}}};
   localparam logic signed [DATA_W-1:0] DMIN = {1'b1, {(DATA_W-1){1'b0}}};
   localparam logic signed [WW-1:0] WMAX = {{(WW-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
   localparam logic signed [WW-1:0] WMIN = {{(WW-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

   logic signed [DATA_W-1:0] s1_x, x_pol;
   gain_t                    s1_g;
   logic                     s1_zero;
   logic signed [PW-1:0]     prod;
   logic signed [WW-1:0]     wide, scaled;
   logic [EXP_W-1:0]         neg_e;
   logic [5:0]               rsh;
   logic signed [DATA_W-1:0] y_nx;

   always_comb begin
      if (!inv)            x_pol = x;
      else if (x == DMIN)  x_pol = DMAX;
      else                 x_pol = -x;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_x    <= '0;
         s1_g    <= '0;
         s1_zero <= 1'b1;
      end else if (take) begin
         s1_x    <= x_pol;
         s1_g    <= gain;
         s1_zero <= !en || gain.mute;
      end
   end

   assign prod  = s1_x * $signed({1'b0, s1_g.mant});
   assign neg_e = -s1_g.expo;
   assign rsh   = 6'(neg_e) + FRAC_SH;

   always_comb begin
      wide = {{(WW-PW){prod[PW-1]}}, prod};
      if (!s1_g.expo[EXP_W-1]) scaled = (wide <<< s1_g.expo[1:0]) >>> FRAC_SH;
      else                     scaled = wide >>> rsh;
      if (s1_zero)             y_nx = '0;
      else if (scaled > WMAX)  y_nx = DMAX;
      else if (scaled < WMIN)  y_nx = DMIN;
      else                     y_nx = scaled[DATA_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        y <= '0;
      else if (s1_valid) y <= y_nx;
   end

   AST_MUTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (take && gain.mute) |-> ##2 (y == '0)); // R4

   AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !en) |-> ##2 (y == '0)); // R9

   AST_INV_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (take && inv && x == DMIN) |=> (s1_x == DMAX)); // R7

endmodule

// File: rtl/dac_vol_path.sv
module dac_vol_path
   import dvp_pkg::*;
#(
   parameter int DATA_W  = 24,
   parameter int MONO_EN = 1
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [1:0]               wr_addr,
   input  logic [15:0]              wr_data,
   input  logic                     in_valid,
   input  logic signed [DATA_W-1:0] in_left,
   input  logic signed [DATA_W-1:0] in_right,
   output logic                     out_valid,
   output logic signed [DATA_W-1:0] out_left,
   output logic signed [DATA_W-1:0] out_right
);

   if (DATA_W < 8 || DATA_W > 32) begin : g_bad_width
      $error("dac_vol_path: DATA_W must lie in 8..32");
   end
   if (MONO_EN != 0 && MONO_EN != 1) begin : g_bad_mono
      $error("dac_vol_path: MONO_EN must be 0 or 1");
   end

   chan_cfg_t [1:0]          cfg;
   logic                     mono;
   logic                     s1_v;
   logic signed [DATA_W-1:0] src [2];
   logic signed [DATA_W-1:0] res [2];
   gain_t                    gain [2];

   dvp_regs u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .cfg     (cfg),
      .mono    (mono)
   );

   if (MONO_EN != 0) begin : g_mono
      logic signed [DATA_W:0] sum;
      assign sum    = {in_left[DATA_W-1], in_left} + {in_right[DATA_W-1], in_right};
      assign src[0] = mono ? sum[DATA_W:1] : in_left;
      assign src[1] = mono ? sum[DATA_W:1] : in_right;
   end else begin : g_stereo
      logic unused_mono;
      assign unused_mono = mono;
      assign src[0] = in_left;
      assign src[1] = in_right;
   end

   for (genvar ch = 0; ch < 2; ch++) begin : g_ch
      dvp_gain_map u_map (
         .code (cfg[ch].code),
         .gain (gain[ch])
      );
      dvp_chan #(.DATA_W(DATA_W)) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .take     (in_valid),
         .s1_valid (s1_v),
         .x        (src[ch]),
         .inv      (cfg[ch].inv),
         .en       (cfg[ch].en),
         .gain     (gain[ch]),
         .y        (res[ch])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_v      <= 1'b0;
         out_valid <= 1'b0;
      end else begin
         s1_v      <= in_valid;
         out_valid <= s1_v;
      end
   end

   assign out_left  = res[0];
   assign out_right = res[1];

   AST_LATENCY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> ##2 out_valid); // R10

   AST_LATENCY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> ##2 !out_valid); // R10

   AST_MONO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mono && MONO_EN != 0 && cfg[0] == cfg[1]) |-> ##2 (out_left == out_right)); // R8

endmodule

// File: tb/dac_vol_path_test.sv
module dac_vol_path_test;

   localparam int W = 16;
   localparam longint MAXV = (64'sd1 <<< (W-1)) - 1;
   localparam longint MINV = -(64'sd1 <<< (W-1));

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic in_valid = 1'b0;
   logic signed [W-1:0] in_left = '0, in_right = '0;
   logic out_valid;
   logic signed [W-1:0] out_left, out_right;

   int vectors = 0;
   int misses = 0;
   bit done = 1'b0;

   int m_code [2];
   bit m_en [2];
   bit m_inv [2];
   bit m_mono = 1'b0;

   always #2 clk = ~clk;

   dac_vol_path #(.DATA_W(W), .MONO_EN(1)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
      .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
   );

   task automatic chk(input string tag, input longint act, input longint exp);
      vectors++;
      if (act != exp) begin
         misses++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic longint sat(input longint v);
      if (v > MAXV) return MAXV;
      if (v < MINV) return MINV;
      return v;
   endfunction

   function automatic longint model(input longint l, input longint r, input int ch);
      longint s, p;
      int k, e;
      longint mant;
      if (!m_en[ch]) return 0;
      s = m_mono ? ((l + r) >>> 1) : ((ch == 0) ? l : r);
      if (m_inv[ch]) s = sat(-s);
      if (m_code[ch] == 0) return 0;
      k = m_code[ch] % 16;
      e = m_code[ch] / 16 - 12;
      mant = longint'($rtoi(16384.0 * (10.0 ** (0.01875 * k)) + 0.5));
      p = s * mant;
      if (e >= 0) p = (p <<< e) >>> 14;
      else        p = p >>> (14 - e);
      return sat(p);
   endfunction

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic set_vol(input int ch, input int code, input bit en, input bit upd);
      wr(ch == 0 ? 2'd1 : 2'd2, {en, 6'd0, upd, 8'(code)});
      m_en[ch] = en;
   endtask

   task automatic smp(input string tag, input longint l, input longint r);
      longint el, er;
      el = model(l, r, 0);
      er = model(l, r, 1);
      @(negedge clk);
      in_valid = 1'b1; in_left = W'(l); in_right = W'(r);
      @(negedge clk);
      in_valid = 1'b0;
      chk({tag, " R10 early"}, longint'(out_valid), 0);
      @(negedge clk);
      chk({tag, " R10 valid"}, longint'(out_valid), 1);
      chk({tag, " left"}, longint'(out_left), el);
      chk({tag, " right"}, longint'(out_right), er);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         misses++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

   initial begin
      longint pats [8] = '{0, 1, -1, 12345, -23456, 32767, -32768, 777};
      m_code[0] = 192; m_code[1] = 192;
      m_en[0] = 0; m_en[1] = 0; m_inv[0] = 0; m_inv[1] = 0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 out_valid", longint'(out_valid), 0);
      chk("R1 out_left", longint'(out_left), 0);
      chk("R1 out_right", longint'(out_right), 0);
      rst_n = 1'b1;
      smp("R1 R9 disabled after reset", 1000, -1000);
      // R1: default code 0xC0 is unity once enabled
      set_vol(0, 8'hC0, 1, 0);
      set_vol(1, 8'hC0, 1, 0);
      smp("R1 R5 unity default", 1234, -4321);

      // R4 R5 R6: sweep every code on both channels
      for (int c = 0; c < 256; c++) begin
         set_vol(0, c, 1, 0);
         set_vol(1, 255 - c, 1, 1);
         m_code[0] = c; m_code[1] = 255 - c;
         for (int p = 0; p < 8; p++)
            smp("R4 R5 R6 sweep", pats[p], pats[7 - p]);
      end

      // R3: pending codes stay inactive until an update write
      set_vol(0, 8'hC0, 1, 1);
      m_code[0] = 192; m_code[1] = 0;
      set_vol(0, 8'h80, 1, 0);
      set_vol(1, 8'h40, 1, 0);
      smp("R3 no update yet", 20000, 20000);
      set_vol(0, 8'h90, 1, 1);
      m_code[0] = 8'h90; m_code[1] = 8'h40;
      smp("R3 joint update", 20000, -20000);

      // R2 R7: inversion through control register
      set_vol(0, 8'hC0, 1, 0);
      set_vol(1, 8'hC0, 1, 1);
      m_code[0] = 192; m_code[1] = 192;
      wr(2'd0, 16'h0003);
      m_inv[0] = 1; m_inv[1] = 1;
      smp("R2 R7 invert extremes", -32768, 32767);
      wr(2'd0, 16'h0001);
      m_inv[1] = 0;
      smp("R2 R7 invert left only", 500, 500);
      wr(2'd3, 16'hFFFF);
      smp("R2 address 3 ignored", -700, 700);

      // R8: mono fold, then per-channel inversion and gain
      wr(2'd0, 16'h0006);
      m_mono = 1; m_inv[0] = 0; m_inv[1] = 1;
      smp("R8 mono", 1001, -2);
      smp("R8 mono extremes", -32768, -32767);
      set_vol(1, 8'hB0, 1, 1);
      m_code[1] = 8'hB0;
      smp("R8 mono gain", 30001, 10000);
      wr(2'd0, 16'h0000);
      m_mono = 0; m_inv[1] = 0;

      // R9: disable right channel only
      set_vol(1, 8'hC0, 0, 1);
      m_code[1] = 192;
      smp("R9 right disabled", 900, 900);
      set_vol(1, 8'hC0, 1, 0);

      // R10: back-to-back samples
      @(negedge clk);
      in_valid = 1'b1; in_left = 16'sd111; in_right = 16'sd222;
      @(negedge clk);
      in_left = -16'sd333; in_right = -16'sd444;
      chk("R10 b2b first early", longint'(out_valid), 0);
      @(negedge clk);
      in_valid = 1'b0;
      chk("R10 b2b first valid", longint'(out_valid), 1);
      chk("R10 b2b first left", longint'(out_left), 111);
      chk("R10 b2b first right", longint'(out_right), 222);
      @(negedge clk);
      chk("R10 b2b second valid", longint'(out_valid), 1);
      chk("R10 b2b second left", longint'(out_left), -333);
      chk("R10 b2b second right", longint'(out_right), -444);
      @(negedge clk);
      chk("R10 b2b idle", longint'(out_valid), 0);

      // R11: write on the same edge as a sample affects only later samples
      @(negedge clk);
      in_valid = 1'b1; in_left = 16'sd1000; in_right = 16'sd2000;
      wr_en = 1'b1; wr_addr = 2'd1; wr_data = {1'b1, 6'd0, 1'b1, 8'h00};
      @(negedge clk);
      in_valid = 1'b0; wr_en = 1'b0;
      @(negedge clk);
      chk("R11 old gain left", longint'(out_left), 1000);
      chk("R11 old gain right", longint'(out_right), 2000);
      m_code[0] = 0;
      smp("R11 R4 new gain", 1000, 2000);

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

endmodule